// File: doc/BRIEF.md
# Transmit Data Link FIFO Controller

This block sits between a processor and the serial transmitter of a data link. The processor loads the outgoing message one byte at a time and tags its last byte as the end of the message. The link transmitter pulls the bytes out with a one-cycle request handshake. The block answers each request with a data byte, a closing-flag command or an abort command. Flag generation, bit stuffing and checksum insertion are done downstream. This block only decides which of those the transmitter sends next.

Four conditions are latched as status events: a mid-message underrun, a write into a full buffer, the fill level dropping below a programmable near-empty threshold, and the completion of a message. Each latched bit holds until a status read clears it. A per-bit enable mask forms a single interrupt line. An underrun makes the transmitter send an abort code and empties the buffer. Requests are then ignored until the processor writes again.

Top module: `tx_link_fifo_ctl`

## Requirements
- R1: Bytes leave in the order they were written. The 9-bit entry (8 data bits plus an end-of-message tag) appears on `tx_data`/`tx_eom` with `tx_valid` high in the cycle after the `drain_req` that removed it.
- R2: A write while 64 bytes are held is discarded and sets status bit 2. The stored contents are unchanged.
- R3: A `drain_req` on an empty buffer, while a message is in progress, makes `abort_cmd` pulse for one cycle in the next cycle and sets status bit 3. No data is output for that request.
- R4: After an abort, `drain_req` produces no data, no abort and no closing flag until the processor writes a byte. That byte then starts a new message.
- R5: The first `drain_req` after an end-of-message byte has been delivered pulses `close_cmd` in the next cycle and sets status bit 0. It takes no byte from the buffer.
- R6: A `drain_req` on an empty buffer with no message in progress is idle. There is no output, no abort and no status change.
- R7: Status bit 1 is set when the fill level falls from at least `near_thresh` to below it. A level that stays below the threshold does not set it again.
- R8: A `stat_rd` pulse clears all latched status bits, except events that occur in the same cycle, which are kept.
- R9: `irq` is high exactly when a latched status bit has its bit set in `irq_en` (bit 3 underrun, 2 overflow, 1 near empty, 0 message sent).
- R10: After reset the status is zero, `irq` is low and `tx_valid`, `abort_cmd` and `close_cmd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Processor byte write strobe |
| wr_data | input | 8 | Byte to store |
| wr_eom | input | 1 | Tags the byte as the last of its message |
| near_thresh | input | 7 | Near-empty fill level threshold |
| drain_req | input | 1 | Transmitter asks for its next item |
| tx_valid | output | 1 | Data byte delivered this cycle |
| tx_data | output | 8 | Delivered byte |
| tx_eom | output | 1 | Delivered byte ends its message |
| abort_cmd | output | 1 | Transmitter must send an abort code |
| close_cmd | output | 1 | Transmitter must begin the closing flag |
| stat_rd | input | 1 | Status read, clears latched events |
| status | output | 4 | Latched events: [3] underrun, [2] overflow, [1] near empty, [0] message sent |
| irq_en | input | 4 | Per-event interrupt enables |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the transmitter asks for at most one item per cycle. They also assume that a processor write happening together with an underrun is still accepted. Under that assumption a delivered byte, an abort and a closing flag are mutually exclusive. Each abort and closing flag must show up in the latched status at the same edge. The bench drives one request or one write per cycle, with inputs changing on falling edges. It keeps the near-empty threshold fixed at 4 so that filling and draining cross the level at predictable points. It never writes in the cycle of an underrun.

// File: rtl/tlf_pkg.sv
package tlf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MSG   = 2'd1,
        ST_CLOSE = 2'd2,
        ST_HOLD  = 2'd3
    } link_st_e;

    localparam int EV_MSG  = 0;
    localparam int EV_NEAR = 1;
    localparam int EV_OVF  = 2;
    localparam int EV_UND  = 3;
    localparam int EV_N    = 4;
endpackage

// File: rtl/tlf_store.sv
module tlf_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tlf_events.sv
module tlf_events #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_i,
    input  logic         clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] stat_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] stat;
    } ev_state_t;

    ev_state_t ev_d, ev_q;

    always_comb begin
        ev_d = ev_q;
        if (clr_i) ev_d.stat = '0;
        ev_d.stat = ev_d.stat | ev_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign stat_o = ev_q.stat;
    assign irq_o  = |(ev_q.stat & en_i);

    // R8
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && ev_i == '0) |=> (stat_o == '0));

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && ev_i == '0) |=> $stable(stat_o));
endmodule

// File: rtl/tx_link_fifo_ctl.sv
module tx_link_fifo_ctl #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int EW = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_eom,
    input  logic [CW-1:0]     near_thresh,
    input  logic              drain_req,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_eom,
    output logic              abort_cmd,
    output logic              close_cmd,
    input  logic              stat_rd,
    output logic [3:0]        status,
    input  logic [3:0]        irq_en,
    output logic              irq
);
    import tlf_pkg::*;

    typedef struct packed {
        logic [AW-1:0]     wp;
        logic [AW-1:0]     rp;
        logic [CW-1:0]     cnt;
        link_st_e          st;
        logic              near;
        logic              out_v;
        logic [DATA_W-1:0] out_d;
        logic              out_eom;
        logic              abort;
        logic              close;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [EW-1:0]   rd_word;
    logic            wr_ok;
    logic            pop;
    logic            underrun;
    logic [EV_N-1:0] ev;
    logic [EV_N-1:0] stat_w;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    tlf_store #(.WIDTH(EW), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (c_q.wp),
        .wdata ({wr_eom, wr_data}),
        .raddr (c_q.rp),
        .rdata (rd_word)
    );

    always_comb begin
        c_d        = c_q;
        c_d.out_v  = 1'b0;
        c_d.abort  = 1'b0;
        c_d.close  = 1'b0;
        ev         = '0;
        pop        = 1'b0;
        underrun   = 1'b0;

        wr_ok      = wr_en && (c_q.cnt != CW'(DEPTH));
        ev[EV_OVF] = wr_en && !wr_ok;

        if (drain_req) begin
            unique case (c_q.st)
                ST_IDLE, ST_MSG: begin
                    if (c_q.cnt != '0)       pop = 1'b1;
                    else if (c_q.st == ST_MSG) underrun = 1'b1;
                end
                ST_CLOSE: begin
                    c_d.close  = 1'b1;
                    ev[EV_MSG] = 1'b1;
                    c_d.st     = ST_IDLE;
                end
                default: ;
            endcase
        end

        if (pop) begin
            c_d.out_v   = 1'b1;
            c_d.out_d   = rd_word[DATA_W-1:0];
            c_d.out_eom = rd_word[DATA_W];
            c_d.rp      = ptr_inc(c_q.rp);
            c_d.st      = rd_word[DATA_W] ? ST_CLOSE : ST_MSG;
        end

        if (wr_ok) c_d.wp = ptr_inc(c_q.wp);

        if (underrun) begin
            c_d.abort  = 1'b1;
            ev[EV_UND] = 1'b1;
            c_d.rp     = c_q.wp;
            c_d.cnt    = CW'(wr_ok);
            c_d.st     = ST_HOLD;
        end else begin
            c_d.cnt = c_q.cnt + CW'(wr_ok) - CW'(pop);
        end

        if (c_d.st == ST_HOLD && wr_ok) c_d.st = ST_IDLE;

        c_d.near    = c_d.cnt < near_thresh;
        ev[EV_NEAR] = c_d.near && !c_q.near;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.st   <= ST_IDLE;
            c_q.near <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    tlf_events #(.N(EV_N)) u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .ev_i  (ev),
        .clr_i (stat_rd),
        .en_i  (irq_en),
        .stat_o(stat_w),
        .irq_o (irq)
    );

    assign tx_valid  = c_q.out_v;
    assign tx_data   = c_q.out_d;
    assign tx_eom    = c_q.out_eom;
    assign abort_cmd = c_q.abort;
    assign close_cmd = c_q.close;
    assign status    = stat_w;

    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt <= CW'(DEPTH));

    // R3
    abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_cmd |-> !(tx_valid || close_cmd));

    // R3
    abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_cmd |-> stat_w[EV_UND]);

    // R5
    close_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        close_cmd |-> (stat_w[EV_MSG] && !tx_valid));

    // R4
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_HOLD && !wr_en) |=> !(tx_valid || abort_cmd || close_cmd));

    // R1
    empty_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.cnt == '0) |=> !tx_valid);
endmodule

// File: tb/tb_tx_link_fifo_ctl.sv
module tb_tx_link_fifo_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_eom = 1'b0;
    logic [6:0] near_thresh = 7'd4;
    logic       drain_req = 1'b0;
    logic       tx_valid, tx_eom, abort_cmd, close_cmd, irq;
    logic [7:0] tx_data;
    logic       stat_rd = 1'b0;
    logic [3:0] status;
    logic [3:0] irq_en = 4'd0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tx_link_fifo_ctl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_eom(wr_eom), .near_thresh(near_thresh), .drain_req(drain_req),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_eom(tx_eom),
        .abort_cmd(abort_cmd), .close_cmd(close_cmd), .stat_rd(stat_rd),
        .status(status), .irq_en(irq_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] d, input logic e);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_eom = e;
        @(negedge clk);
        wr_en = 1'b0; wr_eom = 1'b0;
    endtask

    task automatic pull();
        @(negedge clk);
        drain_req = 1'b1;
        @(negedge clk);
        drain_req = 1'b0;
    endtask

    task automatic clear_stat();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 status", status, 4'h0);
        chk("R10 irq", irq, 1'b0);
        chk("R10 outputs", {tx_valid, abort_cmd, close_cmd}, 3'b000);
    endtask

    task automatic t_basic_message();
        put(8'hA5, 1'b0); put(8'h3C, 1'b0); put(8'h0F, 1'b1);
        pull(); chk("R1 byte0", {tx_valid, tx_eom, tx_data}, {2'b10, 8'hA5});
        pull(); chk("R1 byte1", {tx_valid, tx_eom, tx_data}, {2'b10, 8'h3C});
        pull(); chk("R1 byte2 eom", {tx_valid, tx_eom, tx_data}, {2'b11, 8'h0F});
        chk("R5 no close yet", close_cmd, 1'b0);
        pull();
        chk("R5 close pulse", {close_cmd, tx_valid, abort_cmd}, 3'b100);
        chk("R5 msg bit", status[0], 1'b1);
        pull();
        chk("R6 idle request", {tx_valid, abort_cmd, close_cmd}, 3'b000);
        chk("R6 no error", status[3], 1'b0);
    endtask

    task automatic t_irq_and_clear();
        irq_en = 4'b0000; #1;
        chk("R9 masked", irq, 1'b0);
        irq_en = 4'b0001; #1;
        chk("R9 enabled", irq, 1'b1);
        irq_en = 4'b1110; #1;
        chk("R9 other bits", irq, 1'b0);
        irq_en = 4'b0001;
        clear_stat();
        chk("R8 cleared", status, 4'h0);
        chk("R9 irq drops", irq, 1'b0);
        irq_en = 4'b0000;
    endtask

    task automatic t_underrun();
        put(8'h11, 1'b0); put(8'h22, 1'b0);
        pull(); chk("R1 u byte0", tx_data, 8'h11);
        pull(); chk("R1 u byte1", tx_data, 8'h22);
        pull();
        chk("R3 abort pulse", {abort_cmd, tx_valid, close_cmd}, 3'b100);
        chk("R3 err bit", status[3], 1'b1);
        clear_stat();
        chk("R3 abort one cycle", abort_cmd, 1'b0);
        pull();
        chk("R4 hold quiet", {tx_valid, abort_cmd, close_cmd}, 3'b000);
        chk("R4 no new err", status[3], 1'b0);
        put(8'h33, 1'b1);
        pull(); chk("R4 new msg", {tx_valid, tx_eom, tx_data}, {2'b11, 8'h33});
        pull(); chk("R4 new close", close_cmd, 1'b1);
        clear_stat();
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 64; i++) put(8'(i + 8'h40), i == 63);
        chk("R2 no ovf when filling", status[2], 1'b0);
        put(8'hEE, 1'b0);
        chk("R2 ovf bit", status[2], 1'b1);
        for (int i = 0; i < 64; i++) begin
            pull();
            chk("R2 kept data", {tx_valid, tx_eom, tx_data}, {1'b1, 1'(i == 63), 8'(i + 8'h40)});
        end
        pull(); chk("R2 extra byte dropped", {close_cmd, tx_valid}, 2'b10);
        pull(); chk("R6 idle after full", {tx_valid, abort_cmd}, 2'b00);
        clear_stat();
    endtask

    task automatic t_near_empty();
        for (int i = 0; i < 8; i++) put(8'(i), i == 7);
        chk("R7 no event on fill", status[1], 1'b0);
        for (int i = 0; i < 4; i++) pull();
        chk("R7 level 4 not near", status[1], 1'b0);
        pull();
        chk("R7 level 3 near", status[1], 1'b1);
        clear_stat();
        pull();
        chk("R7 no repeat", status[1], 1'b0);
        pull(); pull();
        chk("R1 last eom", {tx_eom, tx_data}, {1'b1, 8'h07});
        @(negedge clk);
        drain_req = 1'b1; stat_rd = 1'b1;
        @(negedge clk);
        drain_req = 1'b0; stat_rd = 1'b0;
        chk("R8 same-cycle event kept", status, 4'b0001);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_message();
        t_irq_and_clear();
        t_underrun();
        t_overflow();
        t_near_empty();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule